// File: doc/BRIEF.md
# Receive descriptor routing classifier

This block sits at the entry of a receive reordering stage. Each cycle it can accept one 256-bit receive descriptor, made of eight 32-bit words where word k occupies bits [32k+31:32k]. It reads the flag bits and the destination code of the descriptor and produces one routing result. The result carries the 40-bit queue descriptor address, the 12-bit sequence number, a 5-bit exit ring index and four control bits: run reordering, run the packet-number check, block-ack-request, and format error.

A small configuration port writes two kinds of state. The first is a fragment ring register that catches fragments and rejected descriptors. The second is a remap table with one entry for each destination code from 7 to 31. The block also checks descriptors that carry block-ack-request data for a further traffic identifier and no frame of their own ("frameless"). These may have nonzero bits only in a fixed set of fields. When a frameless descriptor breaks that rule, the block routes it as an error and sets a flag that stays set until reset.

The result is held in one output register with a valid/ready handshake, so a stalled consumer sees a steady value.

Top module: `rx_desc_router`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or is being drained in the same cycle. Each accepted descriptor yields exactly one output item, and items leave in acceptance order.
- R2: For a descriptor that is not a fragment and not rejected, a destination code (word 5 bits [26:22]) of 0 to 6 gives that same value as the ring index. The reorder bit is then 1.
- R3: A destination code of 7 to 31 gives the ring index stored in the remap table entry for that code. Every entry is 0 after reset.
- R4: A configuration write with `cfg_frag`=0 and index 7 to 31 changes only that table entry, and the new value is used from the next cycle on. A write with index 0 to 6 changes nothing, so those codes still route to themselves.
- R5: When the fragment flag (word 2 bit 20) is set, the ring index is the fragment ring register, and the reorder and packet-number-check bits are 0. The destination code plays no part. The fragment ring register is 0 after reset and is written with `cfg_frag`=1.
- R6: The packet-number-check bit equals the packet-number-valid flag (word 2 bit 24) for descriptors on the normal path, and is 0 whenever that flag is clear.
- R7: The block-ack-request bit equals word 2 bit 23. The sequence field (word 2 bits [19:8]) and the queue address {word 5 bits [7:0], word 4} are copied to the output unchanged.
- R8: A frameless descriptor (word 5 bit 27 set) whose only nonzero bits lie in word 3, word 4, word 5 bits [7:0], word 5 bit 27, word 2 bits [19:8] and word 2 bit 23 is routed on the normal path, and the format-error flag stays clear.
- R9: A frameless descriptor with any other nonzero bit has its error bit set, is routed to the fragment ring register, and has reorder and packet-number-check bits of 0. It also sets `fmt_err`, which stays 1 until reset.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and every output field stay unchanged.
- R11: When a configuration write and a descriptor acceptance fall in the same cycle, the descriptor is resolved with the table and fragment register contents from before that write.
- R12: After reset, `out_valid` and `fmt_err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_desc | input | 256 | Eight 32-bit words, word k at bits [32k+31:32k] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_frag | input | 1 | 1: write fragment ring register; 0: write remap entry |
| cfg_idx | input | 5 | Remap entry index |
| cfg_val | input | 5 | Ring index value to store |
| out_valid | output | 1 | Routing result present |
| out_ready | input | 1 | Consumer takes result |
| out_qaddr | output | 40 | Queue descriptor address |
| out_seq | output | 12 | Sequence number or window start |
| out_ring | output | 5 | Resolved exit ring index |
| out_reorder | output | 1 | Run reorder processing |
| out_pn_check | output | 1 | Run packet-number check |
| out_bar | output | 1 | Descriptor is a block-ack-request |
| out_err | output | 1 | Descriptor rejected for bad frameless format |
| fmt_err | output | 1 | Sticky format-error flag |

## Verification
A configuration write can land in the same cycle as the acceptance of a descriptor that reads the very state being written. That state is either the remap entry for the descriptor's code or the fragment ring register. The bench provokes this by driving both on one clock edge with backpressure off, so acceptance is certain. It expects the value held before the write, and then sends the same descriptor again and expects the new value. Random traffic under backpressure mixes configuration writes between descriptors, and the scoreboard model updates its copy of the table only after it has computed the result of the descriptor that shared the cycle with the write.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 8;
  localparam int DESC_W     = WORD_W * NUM_WORDS;
  localparam int CODE_W     = 5;
  localparam int NUM_CODES  = 1 << CODE_W;
  localparam int FIXED_CODES = 7;
  localparam int RING_W     = 5;
  localparam int SEQ_W      = 12;
  localparam int QLO_W      = 32;
  localparam int QHI_W      = 8;
  localparam int QADDR_W    = QLO_W + QHI_W;

  // word 2 bit positions
  localparam int W2_SEQ_LSB = 8;
  localparam int W2_FRAG    = 20;
  localparam int W2_BAR     = 23;
  localparam int W2_PNOK    = 24;
  // word 5 bit positions
  localparam int W5_DEST_LSB = 22;
  localparam int W5_FLESS    = 27;

  typedef struct packed {
    logic [QADDR_W-1:0] qaddr;
    logic [SEQ_W-1:0]   seq;
    logic [RING_W-1:0]  ring;
    logic               reorder;
    logic               pn_check;
    logic               bar;
    logic               err;
  } route_t;

  // Bits a frameless descriptor may carry as nonzero, per word.
  function automatic logic [WORD_W-1:0] fless_keep(input int unsigned w);
    logic [WORD_W-1:0] m;
    m = '0;
    case (w)
      2: begin
        m = ((WORD_W'(1) << SEQ_W) - WORD_W'(1)) << W2_SEQ_LSB;
        m[W2_BAR] = 1'b1;
      end
      3, 4: m = '1;
      5: begin
        m = (WORD_W'(1) << QHI_W) - WORD_W'(1);
        m[W5_FLESS] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [DESC_W-1:0] d,
                                               input int unsigned w);
    return d[w*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/rdr_field_decode.sv
module rdr_field_decode
  import rdr_pkg::*;
(
  input  logic [DESC_W-1:0]  desc,
  output logic [CODE_W-1:0]  dest_code,
  output logic               is_frag,
  output logic               pn_ok,
  output logic               is_bar,
  output logic               is_fless,
  output logic               fless_bad,
  output logic [SEQ_W-1:0]   seq,
  output logic [QADDR_W-1:0] qaddr
);
  logic [WORD_W-1:0]    w2, w4, w5;
  logic [NUM_WORDS-1:0] word_bad;

  assign w2 = word_of(desc, 2);
  assign w4 = word_of(desc, 4);
  assign w5 = word_of(desc, 5);

  assign dest_code = w5[W5_DEST_LSB +: CODE_W];
  assign is_fless  = w5[W5_FLESS];
  assign is_frag   = w2[W2_FRAG];
  assign pn_ok     = w2[W2_PNOK];
  assign is_bar    = w2[W2_BAR];
  assign seq       = w2[W2_SEQ_LSB +: SEQ_W];
  assign qaddr     = {w5[QHI_W-1:0], w4};

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign word_bad[k] = |(desc[k*WORD_W +: WORD_W] & ~fless_keep(k));
  end

  assign fless_bad = |word_bad;
endmodule

// File: rtl/rdr_remap_table.sv
module rdr_remap_table #(
  parameter int NUM_CODES   = 32,
  parameter int FIXED_CODES = 7,
  parameter int RING_W      = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_CODES)-1:0] wr_idx,
  input  logic [RING_W-1:0]            wr_val,
  input  logic [$clog2(NUM_CODES)-1:0] rd_code,
  output logic [RING_W-1:0]            rd_ring,
  output logic                         wr_taken
);
  localparam int CODE_W = $clog2(NUM_CODES);
  localparam logic [CODE_W-1:0] FIX_LIM = CODE_W'(FIXED_CODES);

  logic [NUM_CODES-1:0][RING_W-1:0] slot;

  assign wr_taken = wr_en && (wr_idx >= FIX_LIM);

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_slot
    if (g < FIXED_CODES) begin : g_fixed
      assign slot[g] = RING_W'(g);
    end else begin : g_entry
      logic [RING_W-1:0] entry_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                   entry_q <= '0;
        else if (wr_taken && wr_idx == CODE_W'(g))    entry_q <= wr_val;
      end
      assign slot[g] = entry_q;
    end
  end

  assign rd_ring = slot[rd_code];

  // R4: low-index writes leave the table untouched
  p_low_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < FIX_LIM) |=> $stable(slot));

  // R4: a taken write lands in its entry
  p_remap_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_taken |=> slot[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/rdr_out_reg.sv
module rdr_out_reg
  import rdr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  input  route_t nxt,
  output logic   out_valid,
  input  logic   out_ready,
  output route_t q
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      q         <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled result holds still
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));

  // R1: an accepted descriptor is presented next cycle
  p_accept_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

// File: rtl/rx_desc_router.sv
module rx_desc_router
  import rdr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DESC_W-1:0]    in_desc,
  input  logic                 cfg_we,
  input  logic                 cfg_frag,
  input  logic [CODE_W-1:0]    cfg_idx,
  input  logic [RING_W-1:0]    cfg_val,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [QADDR_W-1:0]   out_qaddr,
  output logic [SEQ_W-1:0]     out_seq,
  output logic [RING_W-1:0]    out_ring,
  output logic                 out_reorder,
  output logic                 out_pn_check,
  output logic                 out_bar,
  output logic                 out_err,
  output logic                 fmt_err
);
  localparam logic [CODE_W-1:0] FIX_LIM = CODE_W'(FIXED_CODES);

  logic [CODE_W-1:0]  dest_code;
  logic               is_frag, pn_ok, is_bar, is_fless, fless_bad;
  logic [SEQ_W-1:0]   seq;
  logic [QADDR_W-1:0] qaddr;
  logic [RING_W-1:0]  remap_ring;
  logic               remap_taken;
  logic [RING_W-1:0]  frag_ring_q;
  logic               fmt_err_q;
  route_t             nxt, q;

  // named internal events
  logic accept, fl_reject, frag_path;

  rdr_field_decode u_decode (
    .desc      (in_desc),
    .dest_code (dest_code),
    .is_frag   (is_frag),
    .pn_ok     (pn_ok),
    .is_bar    (is_bar),
    .is_fless  (is_fless),
    .fless_bad (fless_bad),
    .seq       (seq),
    .qaddr     (qaddr)
  );

  rdr_remap_table #(
    .NUM_CODES   (NUM_CODES),
    .FIXED_CODES (FIXED_CODES),
    .RING_W      (RING_W)
  ) u_remap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && !cfg_frag),
    .wr_idx   (cfg_idx),
    .wr_val   (cfg_val),
    .rd_code  (dest_code),
    .rd_ring  (remap_ring),
    .wr_taken (remap_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 frag_ring_q <= '0;
    else if (cfg_we && cfg_frag) frag_ring_q <= cfg_val;
  end

  assign accept    = in_valid && in_ready;
  assign fl_reject = is_fless && fless_bad;
  assign frag_path = is_frag && !fl_reject;

  always_comb begin
    nxt.qaddr = qaddr;
    nxt.seq   = seq;
    nxt.bar   = is_bar;
    if (fl_reject) begin
      nxt.ring     = frag_ring_q;
      nxt.reorder  = 1'b0;
      nxt.pn_check = 1'b0;
      nxt.err      = 1'b1;
    end else if (frag_path) begin
      nxt.ring     = frag_ring_q;
      nxt.reorder  = 1'b0;
      nxt.pn_check = 1'b0;
      nxt.err      = 1'b0;
    end else begin
      nxt.ring     = remap_ring;
      nxt.reorder  = 1'b1;
      nxt.pn_check = pn_ok;
      nxt.err      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  fmt_err_q <= 1'b0;
    else if (accept && fl_reject) fmt_err_q <= 1'b1;
  end

  rdr_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .nxt       (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (q)
  );

  assign out_qaddr    = q.qaddr;
  assign out_seq      = q.seq;
  assign out_ring     = q.ring;
  assign out_reorder  = q.reorder;
  assign out_pn_check = q.pn_check;
  assign out_bar      = q.bar;
  assign out_err      = q.err;
  assign fmt_err      = fmt_err_q;

  // R2: low codes route to themselves
  p_fixed_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_fless && !is_frag && dest_code < FIX_LIM)
      |=> (out_ring == $past(dest_code) && out_reorder));

  // R5: fragments bypass reordering toward the fragment ring
  p_frag_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frag_path)
      |=> (!out_reorder && !out_pn_check && out_ring == $past(frag_ring_q)));

  // R6: no packet-number check without the valid flag
  p_pn_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pn_ok) |=> !out_pn_check);

  // R9: rejected frameless descriptors are marked and not reordered
  p_reject_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fl_reject) |=> (out_err && !out_reorder && fmt_err));

  // R9: the format-error flag never clears on its own
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);
endmodule

// File: tb/test_rx_desc_router.sv
`timescale 1ns/1ps
module test_rx_desc_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_desc = '0;
  logic         cfg_we = 1'b0;
  logic         cfg_frag = 1'b0;
  logic [4:0]   cfg_idx = '0;
  logic [4:0]   cfg_val = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [39:0]  out_qaddr;
  logic [11:0]  out_seq;
  logic [4:0]   out_ring;
  logic         out_reorder, out_pn_check, out_bar, out_err, fmt_err;

  always #2.5 clk = ~clk;

  rx_desc_router i_rx_desc_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .cfg_we(cfg_we), .cfg_frag(cfg_frag), .cfg_idx(cfg_idx),
    .cfg_val(cfg_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_qaddr(out_qaddr), .out_seq(out_seq), .out_ring(out_ring),
    .out_reorder(out_reorder), .out_pn_check(out_pn_check), .out_bar(out_bar),
    .out_err(out_err), .fmt_err(fmt_err)
  );

  typedef struct packed {
    logic [39:0] qaddr;
    logic [11:0] seq;
    logic [4:0]  ring;
    logic        ro, pn, bar, err;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   hold = 0;
  bit   bp_en = 0;
  exp_t exp_q[$];
  string tag_q[$];
  logic [4:0] sh_tbl [32];
  logic [4:0] sh_frag = '0;

  initial for (int i = 0; i < 32; i++) sh_tbl[i] = '0;

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic logic [255:0] mk(input logic [4:0] code, input bit frag,
      input bit pn, input bit bar, input bit fl, input logic [11:0] seq,
      input logic [39:0] qa, input logic [31:0] meta);
    logic [255:0] d;
    d = '0;
    d[72 +: 12]  = seq;
    d[84]        = frag;
    d[87]        = bar;
    d[88]        = pn;
    d[96 +: 32]  = meta;
    d[128 +: 32] = qa[31:0];
    d[160 +: 8]  = qa[39:32];
    d[182 +: 5]  = code;
    d[187]       = fl;
    return d;
  endfunction

  function automatic exp_t model(input logic [255:0] d);
    exp_t e;
    logic [255:0] rest;
    logic [4:0] code;
    bit viol;
    code = d[182 +: 5];
    rest = d;
    rest[96 +: 32]  = '0;
    rest[128 +: 32] = '0;
    rest[160 +: 8]  = '0;
    rest[187]       = 1'b0;
    rest[72 +: 12]  = '0;
    rest[87]        = 1'b0;
    viol = (rest != '0);
    e.qaddr = {d[160 +: 8], d[128 +: 32]};
    e.seq   = d[72 +: 12];
    e.bar   = d[87];
    if (d[187] && viol) begin
      e.ring = sh_frag; e.ro = 0; e.pn = 0; e.err = 1;
    end else if (d[84]) begin
      e.ring = sh_frag; e.ro = 0; e.pn = 0; e.err = 0;
    end else begin
      e.ring = (code <= 5'd6) ? code : sh_tbl[code];
      e.ro = 1; e.pn = d[88]; e.err = 0;
    end
    return e;
  endfunction

  task automatic send(input logic [255:0] d, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_desc  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(d));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic cfg_write(input bit fr, input logic [4:0] idx, input logic [4:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_frag = fr; cfg_idx = idx; cfg_val = val;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (fr) sh_frag = val;
    else if (idx >= 5'd7) sh_tbl[idx] = val;
  endtask

  // R11: write and descriptor on the same edge; the descriptor sees old state
  task automatic send_with_write(input bit fr, input logic [4:0] idx,
      input logic [4:0] val, input logic [255:0] d, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_frag = fr; cfg_idx = idx; cfg_val = val;
    in_valid = 1'b1; in_desc = d;
    #1;
    chk(in_ready == 1'b1, tag, $sformatf("in_ready=%0b exp=1", in_ready));
    exp_q.push_back(model(d));
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    cfg_we = 1'b0; in_valid = 1'b0;
    if (fr) sh_frag = val;
    else if (idx >= 5'd7) sh_tbl[idx] = val;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  // consumer readiness
  always @(negedge clk)
    out_ready <= hold ? 1'b0 : (bp_en ? ($urandom % 4 != 0) : 1'b1);

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        exp_t e, g;
        string t;
        g = '{out_qaddr, out_seq, out_ring, out_reorder, out_pn_check, out_bar, out_err};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected output item, actual=extra expected=none");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(g == e, t, $sformatf(
            "actual q=%h s=%h ring=%0d ro=%0b pn=%0b bar=%0b err=%0b expected q=%h s=%h ring=%0d ro=%0b pn=%0b bar=%0b err=%0b",
            g.qaddr, g.seq, g.ring, g.ro, g.pn, g.bar, g.err,
            e.qaddr, e.seq, e.ring, e.ro, e.pn, e.bar, e.err));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] d;
    exp_t cap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R12
    chk(out_valid == 1'b0, "R12", $sformatf("out_valid=%0b exp=0", out_valid));
    chk(fmt_err == 1'b0, "R12", $sformatf("fmt_err=%0b exp=0", fmt_err));
    chk(in_ready == 1'b1, "R12", $sformatf("in_ready=%0b exp=1", in_ready));

    // R3 / R5: reset contents of table and fragment register
    send(mk(5'd20, 0, 1, 0, 0, 12'h123, 40'h12_3456_789A, 32'h0), "R3");
    send(mk(5'd9,  1, 1, 0, 0, 12'h001, 40'h00_0000_0001, 32'h0), "R5");
    drain();

    cfg_write(1, 5'd0, 5'd17);
    cfg_write(0, 5'd7, 5'd12);
    cfg_write(0, 5'd31, 5'd30);
    cfg_write(0, 5'd20, 5'd5);
    cfg_write(0, 5'd3, 5'd9);   // ignored

    // R2 / R6: fixed codes with alternating packet-number flag
    for (int c = 0; c < 7; c++)
      send(mk(5'(c), 0, c[0], 0, 0, 12'(c * 37), {8'(c), 32'hA5A5_0000 + c}, 32'h0), "R2");
    // R4: code 3 still routes to 3 after the low-index write
    send(mk(5'd3, 0, 0, 0, 0, 12'h0, 40'h0, 32'h0), "R4");
    // R3: remapped codes
    send(mk(5'd7,  0, 1, 0, 0, 12'hFFF, 40'hFF_FFFF_FFFF, 32'h0), "R3");
    send(mk(5'd20, 0, 0, 0, 0, 12'h800, 40'h80_0000_0000, 32'h0), "R3");
    send(mk(5'd31, 0, 1, 0, 0, 12'h7FF, 40'h01_0203_0405, 32'h0), "R3");
    // R5: fragment with remapped code and pn set; fragment number present
    d = mk(5'd20, 1, 1, 0, 0, 12'h055, 40'h0A_0B0C_0D0E, 32'h0);
    d[199 +: 4] = 4'hB;
    send(d, "R5");
    // R7: block-ack-request carries window start
    send(mk(5'd5, 0, 1, 1, 0, 12'hABC, 40'h33_4455_6677, 32'h0), "R7");
    drain();

    // R8: clean frameless descriptor
    send(mk(5'd0, 0, 0, 1, 1, 12'h321, 40'h9F_8E7D_6C5B, 32'hDEAD_BEEF), "R8");
    drain();
    chk(fmt_err == 1'b0, "R8", $sformatf("fmt_err=%0b exp=0", fmt_err));

    // R9: frameless with a stray bit in word 7, then with the fragment bit
    d = mk(5'd0, 0, 0, 1, 1, 12'h111, 40'h11_2233_4455, 32'h1);
    d[7*32 + 25] = 1'b1;
    send(d, "R9");
    send(mk(5'd0, 1, 0, 0, 1, 12'h222, 40'h0, 32'h0), "R9");
    send(mk(5'd2, 0, 0, 0, 0, 12'h0, 40'h0, 32'h0), "R9");
    drain();
    chk(fmt_err == 1'b1, "R9", $sformatf("fmt_err=%0b exp=1", fmt_err));

    // R10: stalled output stays put
    hold = 1;
    repeat (2) @(negedge clk);
    send(mk(5'd31, 0, 1, 1, 0, 12'h5A5, 40'h5A_5A5A_5A5A, 32'h0), "R10");
    @(negedge clk);
    #2;
    cap = '{out_qaddr, out_seq, out_ring, out_reorder, out_pn_check, out_bar, out_err};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #2;
      chk(out_valid && cap == '{out_qaddr, out_seq, out_ring, out_reorder,
          out_pn_check, out_bar, out_err}, "R10",
          $sformatf("valid=%0b ring=%0d exp valid=1 ring=%0d", out_valid, out_ring, cap.ring));
    end
    hold = 0;
    drain();

    // R11: same-cycle write to the entry being read, then the new value
    send_with_write(0, 5'd20, 5'd22, mk(5'd20, 0, 0, 0, 0, 12'h0, 40'h7, 32'h0), "R11");
    send(mk(5'd20, 0, 0, 0, 0, 12'h0, 40'h8, 32'h0), "R11");
    send_with_write(1, 5'd0, 5'd3, mk(5'd1, 1, 0, 0, 0, 12'h0, 40'h9, 32'h0), "R11");
    send(mk(5'd1, 1, 0, 0, 0, 12'h0, 40'hA, 32'h0), "R11");
    drain();

    // R1: random traffic under backpressure, with interleaved writes
    bp_en = 1;
    for (int i = 0; i < 120; i++) begin
      bit fl;
      fl = ($urandom % 5 == 0);
      if (fl) begin
        d = mk(5'd0, 0, 0, $urandom % 2, 1, 12'($urandom), {8'($urandom), 32'($urandom)}, 32'($urandom));
        if ($urandom % 2 == 0) d[$urandom % 256] = 1'b1;
      end else begin
        d = mk(5'($urandom), $urandom % 4 == 0, $urandom % 2, $urandom % 2, 0,
               12'($urandom), {8'($urandom), 32'($urandom)}, 32'($urandom));
        d[6*32 +: 32] = 32'($urandom);
      end
      send(d, "R1");
      if (i % 10 == 9) cfg_write($urandom % 4 == 0, 5'($urandom), 5'($urandom));
    end
    bp_en = 0;
    drain();
    chk(exp_q.size() == 0, "R1", $sformatf("pending=%0d exp=0", exp_q.size()));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule